// File: doc/BRIEF.md
# Second-Operand Shifter for Data-Processing Instructions

This block produces the second ALU operand, and the carry that the shifter generates, for a 32-bit data-processing instruction. It takes four inputs: the instruction word, the value already read from the second-operand register, the value read from the shift-amount register, and the current carry flag. From these it selects one of three operand forms:

- an 8-bit constant rotated by an even amount;
- a register shifted by a constant amount;
- a register shifted by an amount held in another register.

It also raises a flag when the encoding is not allowed.

The encodings with a constant amount of zero are rewritten into their special meanings before the shift is done. The shift itself is one shared unit that handles every type and every amount from 0 to 255. A parameter chooses whether the results leave through a register stage (the default, one cycle of latency) or go straight out of the logic.

Top module: `operand_shifter`

## Requirements
- R1: When bit 25 is 1, the operand is bits 7:0 zero-extended and rotated right by twice the value in bits 11:8. The carry-out is bit 31 of that result when the rotate amount is nonzero, and the carry input otherwise.
- R2: When bit 25 is 0 and bit 4 is 0, the operand is the register value shifted by bits 11:7, with the type taken from bits 6:5 (00 left, 01 logical right, 10 arithmetic right, 11 rotate right). Logical right fills with zeros, arithmetic right fills with copies of bit 31, and rotate wraps bits around. For a nonzero amount the carry-out is the last bit shifted out.
- R3: With a constant amount of zero, a left shift passes the value through with the carry input unchanged. Logical right by zero acts as a shift by 32 (result 0, carry = bit 31). Arithmetic right by zero also acts as a shift by 32 (every bit and the carry = bit 31).
- R4: A constant-amount rotate of zero is a one-bit rotate right through carry: the result is {carry input, value[31:1]} and the carry-out is value[0].
- R5: When bit 25 is 0 and bit 4 is 1, the amount is bits 7:0 of the shift-amount register value; the upper bits are ignored. An amount of zero passes both the value and the carry input through unchanged.
- R6: For logical shifts by 32 or more the result is 0. At exactly 32 the carry is bit 0 for a left shift and bit 31 for a right shift; above 32 the carry is 0.
- R7: For arithmetic right by 32 or more, every bit and the carry equal bit 31. A rotate uses the amount modulo 32; a nonzero multiple of 32 leaves the value unchanged with carry = bit 31.
- R8: The undefined flag is 1 exactly when bit 25 is 0, bit 4 is 1 and bit 7 is 1. Bits 31:26, bits 24:12, and any input not used by the selected form have no effect.
- R9: With the output stage enabled, the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of the register to be shifted |
| rs_val_i | input | 32 | Value of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |
| undef_o | output | 1 | Disallowed encoding |

## Verification
The bench pushes hand-computed expectations into a scoreboard, aiming at the encodings where a careless shifter goes wrong:

- **Zero constant amounts.** A design that treats these literally returns the input where 0 or all ones is due, or drops the carry input that a rotate through carry must put into bit 31.
- **Register amounts at 32, just above 32, and far above 32.** Rotate amounts that are multiples of 32 are included. Carry selection that indexes the value naively reads a wrong or wrapped bit here, and a rotate that does not reduce its amount gives zero.
- **Unrotated constants, register amounts with nonzero upper bits, and the undefined encoding.** These catch a carry taken from the result when it should come from the flag, amounts that are not masked to 8 bits, and a flag raised on the constant forms.

// File: rtl/opshf_pkg.sv
// Package: shared widths, field positions and decode record for the
// second-operand shifter. Assumes a 32-bit instruction word.
package opshf_pkg;
    localparam int WORD_W  = 32;
    localparam int AMT_W   = 8;
    localparam int LOG_W   = $clog2(WORD_W);
    localparam int IMM_W   = 8;
    localparam int ROT_W   = 4;
    localparam int SHI_W   = 5;

    // Bit positions the decoder relies on
    localparam int BIT_IMM_FORM  = 25;
    localparam int BIT_REG_AMT   = 4;
    localparam int BIT_MBZ       = 7;
    localparam int ROT_LSB       = 8;
    localparam int SHI_LSB       = 7;
    localparam int TYPE_LSB      = 5;

    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic                 use_imm;
        logic [IMM_W-1:0]     imm8;
        logic                 amt_from_reg;
        logic [AMT_W-1:0]     fixed_amt;
        shift_kind_e          kind;
        logic                 undef;
    } shf_ctrl_t;
endpackage

// File: rtl/opshf_decode.sv
// Module: opshf_decode
// Turns the instruction word into shifter controls. It rewrites the
// zero-amount constant encodings (shift by 32, rotate through carry) and
// flags the disallowed register-amount encoding. Purely combinational.
module opshf_decode
    import opshf_pkg::*;
(
    input  logic [WORD_W-1:0] insn_i,
    output shf_ctrl_t         ctrl_o
);
    logic [1:0]       ty;
    logic [SHI_W-1:0] shi;
    logic [ROT_W-1:0] rot;

    assign ty  = insn_i[TYPE_LSB +: 2];
    assign shi = insn_i[SHI_LSB +: SHI_W];
    assign rot = insn_i[ROT_LSB +: ROT_W];

    // Purpose: select the operand form and resolve the effective amount.
    always_comb begin
        ctrl_o              = '0;
        ctrl_o.imm8         = insn_i[IMM_W-1:0];
        ctrl_o.kind         = SK_LSL;
        if (insn_i[BIT_IMM_FORM]) begin
            ctrl_o.use_imm   = 1'b1;
            ctrl_o.kind      = SK_ROR;
            ctrl_o.fixed_amt = AMT_W'({rot, 1'b0});
        end else begin
            ctrl_o.kind = shift_kind_e'({1'b0, ty});
            if (insn_i[BIT_REG_AMT]) begin
                ctrl_o.amt_from_reg = 1'b1;
                ctrl_o.undef        = insn_i[BIT_MBZ];
            end else if (shi == '0) begin
                unique case (ty)
                    2'b00: ctrl_o.fixed_amt = '0;
                    2'b01,
                    2'b10: ctrl_o.fixed_amt = AMT_W'(WORD_W);
                    2'b11: begin
                        ctrl_o.kind      = SK_RRX;
                        ctrl_o.fixed_amt = AMT_W'(1);
                    end
                    default: ctrl_o.fixed_amt = '0;
                endcase
            end else begin
                ctrl_o.fixed_amt = AMT_W'(shi);
            end
        end
    end
endmodule

// File: rtl/opshf_source.sv
// Module: opshf_source
// Picks the value to shift (zero-extended constant or register) and the
// amount (resolved constant or low byte of the amount register).
module opshf_source
    import opshf_pkg::*;
(
    input  shf_ctrl_t         ctrl_i,
    input  logic [WORD_W-1:0] rm_val_i,
    input  logic [WORD_W-1:0] rs_val_i,
    output logic [WORD_W-1:0] value_o,
    output logic [AMT_W-1:0]  amt_o
);
    // Purpose: operand value mux.
    always_comb begin
        if (ctrl_i.use_imm) value_o = WORD_W'(ctrl_i.imm8);
        else                value_o = rm_val_i;
    end

    // Purpose: shift amount mux, only the low byte of the register counts.
    always_comb begin
        if (ctrl_i.amt_from_reg) amt_o = rs_val_i[AMT_W-1:0];
        else                     amt_o = ctrl_i.fixed_amt;
    end
endmodule

// File: rtl/opshf_barrel.sv
// Module: opshf_barrel
// Shared shift unit for all kinds and amounts 0..2^AMT_W-1. Assumes the
// amount already carries any zero-encoding rewrite; amount 0 passes the
// value and the carry input through.
module opshf_barrel
    import opshf_pkg::*;
(
    input  logic [WORD_W-1:0] value_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shift_kind_e       kind_i,
    input  logic              carry_i,
    output logic [WORD_W-1:0] result_o,
    output logic              carry_o
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WORD_W);

    logic [LOG_W-1:0] up_idx;
    logic [LOG_W-1:0] dn_idx;
    logic [LOG_W-1:0] rot_amt;

    assign up_idx  = LOG_W'(WORD_W - int'(amt_i));
    assign dn_idx  = LOG_W'(amt_i - AMT_W'(1));
    assign rot_amt = amt_i[LOG_W-1:0];

    // Purpose: compute shifted value and shifter carry for every kind.
    always_comb begin
        result_o = value_i;
        carry_o  = carry_i;
        unique case (kind_i)
            SK_RRX: begin
                result_o = {carry_i, value_i[WORD_W-1:1]};
                carry_o  = value_i[0];
            end
            SK_LSL: begin
                if (amt_i == '0) begin
                    result_o = value_i;
                end else if (amt_i < FULL) begin
                    result_o = value_i << amt_i;
                    carry_o  = value_i[up_idx];
                end else if (amt_i == FULL) begin
                    result_o = '0;
                    carry_o  = value_i[0];
                end else begin
                    result_o = '0;
                    carry_o  = 1'b0;
                end
            end
            SK_LSR: begin
                if (amt_i == '0) begin
                    result_o = value_i;
                end else if (amt_i < FULL) begin
                    result_o = value_i >> amt_i;
                    carry_o  = value_i[dn_idx];
                end else if (amt_i == FULL) begin
                    result_o = '0;
                    carry_o  = value_i[WORD_W-1];
                end else begin
                    result_o = '0;
                    carry_o  = 1'b0;
                end
            end
            SK_ASR: begin
                if (amt_i == '0) begin
                    result_o = value_i;
                end else if (amt_i < FULL) begin
                    result_o = WORD_W'($signed(value_i) >>> amt_i);
                    carry_o  = value_i[dn_idx];
                end else begin
                    result_o = {WORD_W{value_i[WORD_W-1]}};
                    carry_o  = value_i[WORD_W-1];
                end
            end
            SK_ROR: begin
                if (amt_i == '0) begin
                    result_o = value_i;
                end else if (rot_amt == '0) begin
                    result_o = value_i;
                    carry_o  = value_i[WORD_W-1];
                end else begin
                    result_o = (value_i >> rot_amt) |
                               (value_i << (WORD_W - int'(rot_amt)));
                    carry_o  = result_o[WORD_W-1];
                end
            end
            default: begin
                result_o = value_i;
                carry_o  = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/operand_shifter.sv
// Module: operand_shifter (top)
// Second-operand shifter: decode, source select, shared barrel unit and an
// optional output register (OUT_REG). Assumes register values are already
// read; synchronous active-low reset clears the registered outputs.
module operand_shifter
    import opshf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] insn_i,
    input  logic [WORD_W-1:0] rm_val_i,
    input  logic [WORD_W-1:0] rs_val_i,
    input  logic              carry_i,
    output logic [WORD_W-1:0] operand_o,
    output logic              carry_o,
    output logic              undef_o
);
    shf_ctrl_t         ctrl;
    logic [WORD_W-1:0] value;
    logic [AMT_W-1:0]  amt;
    logic [WORD_W-1:0] sh_res;
    logic              sh_cry;

    opshf_decode u_dec (
        .insn_i (insn_i),
        .ctrl_o (ctrl)
    );

    opshf_source u_src (
        .ctrl_i   (ctrl),
        .rm_val_i (rm_val_i),
        .rs_val_i (rs_val_i),
        .value_o  (value),
        .amt_o    (amt)
    );

    opshf_barrel u_bar (
        .value_i  (value),
        .amt_i    (amt),
        .kind_i   (ctrl.kind),
        .carry_i  (carry_i),
        .result_o (sh_res),
        .carry_o  (sh_cry)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Purpose: one-cycle output stage with synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    operand_o <= '0;
                    carry_o   <= 1'b0;
                    undef_o   <= 1'b0;
                end else begin
                    operand_o <= sh_res;
                    carry_o   <= sh_cry;
                    undef_o   <= ctrl.undef;
                end
            end

            // R1: unrotated constant passes imm8 and the incoming carry
            a_r1_unrotated_imm: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_i[BIT_IMM_FORM] && insn_i[ROT_LSB +: ROT_W] == '0) |=>
                (operand_o == WORD_W'($past(insn_i[IMM_W-1:0])) && carry_o == $past(carry_i)));

            // R3: logical right by constant zero behaves as shift by 32
            a_r3_lsr_zero_is_32: assert property (@(posedge clk) disable iff (!rst_n)
                (!insn_i[BIT_IMM_FORM] && !insn_i[BIT_REG_AMT] &&
                 insn_i[SHI_LSB +: SHI_W] == '0 && insn_i[TYPE_LSB +: 2] == 2'b01) |=>
                (operand_o == '0 && carry_o == $past(rm_val_i[WORD_W-1])));

            // R4: rotate through carry
            a_r4_rrx: assert property (@(posedge clk) disable iff (!rst_n)
                (!insn_i[BIT_IMM_FORM] && !insn_i[BIT_REG_AMT] &&
                 insn_i[SHI_LSB +: SHI_W] == '0 && insn_i[TYPE_LSB +: 2] == 2'b11) |=>
                (operand_o == {$past(carry_i), $past(rm_val_i[WORD_W-1:1])} &&
                 carry_o == $past(rm_val_i[0])));

            // R5: register amount with zero low byte passes everything through
            a_r5_zero_reg_amount: assert property (@(posedge clk) disable iff (!rst_n)
                (!insn_i[BIT_IMM_FORM] && insn_i[BIT_REG_AMT] && rs_val_i[AMT_W-1:0] == '0) |=>
                (operand_o == $past(rm_val_i) && carry_o == $past(carry_i)));

            // R8: undefined flag only for the register-amount form
            a_r8_undef_source: assert property (@(posedge clk) disable iff (!rst_n)
                undef_o |-> $past(!insn_i[BIT_IMM_FORM] && insn_i[BIT_REG_AMT]));
        end else begin : g_comb
            assign operand_o = sh_res;
            assign carry_o   = sh_cry;
            assign undef_o   = ctrl.undef;
        end
    endgenerate
endmodule

// File: tb/sim_operand_shifter.sv
// Scoreboard bench: the driver pushes hand-computed expectations, the
// monitor pops and compares one cycle after each applied vector.
module sim_operand_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] rm = '0;
    logic [31:0] rs = '0;
    logic        cin = 1'b0;
    logic [31:0] op;
    logic        cout;
    logic        und;
    logic        in_valid = 1'b0;
    logic        done = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    typedef struct {
        logic [31:0] op;
        logic        c;
        logic        u;
        bit          chk_data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    operand_shifter u0 (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .rm_val_i(rm),
        .rs_val_i(rs), .carry_i(cin), .operand_o(op), .carry_o(cout),
        .undef_o(und)
    );

    function automatic logic [31:0] f_imm(logic [31:0] hi, logic [3:0] rot, logic [7:0] v);
        return (hi & 32'hFDFF_F000) | 32'h0200_0000 | {20'd0, rot, v};
    endfunction
    function automatic logic [31:0] f_rsi(logic [4:0] sh, logic [1:0] ty);
        return 32'hE1A0_0003 | (32'(sh) << 7) | (32'(ty) << 5);
    endfunction
    function automatic logic [31:0] f_rsr(logic [1:0] ty, logic b7);
        return 32'hE1B0_0213 | (32'(ty) << 5) | (32'(b7) << 7);
    endfunction

    task automatic check(string tag, logic [31:0] a, logic [31:0] e);
        n_run++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic drive(logic [31:0] i, logic [31:0] m, logic [31:0] s, logic c,
                         logic [31:0] eo, logic ec, logic eu, bit cd, string tag);
        exp_t e;
        @(negedge clk);
        insn = i; rm = m; rs = s; cin = c; in_valid = 1'b1;
        e.op = eo; e.c = ec; e.u = eu; e.chk_data = cd; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one cycle after each applied vector.
    always @(posedge clk) begin
        if (in_valid) begin
            exp_t e;
            #2;
            e = sb.pop_front();
            if (e.chk_data) begin
                check({e.tag, " operand"}, op, e.op);
                check({e.tag, " carry"}, {31'd0, cout}, {31'd0, e.c});
            end
            check({e.tag, " undef"}, {31'd0, und}, {31'd0, e.u});
        end
    end

    initial begin
        insn = f_imm(32'hE000_0000, 4'd2, 8'hFF); rm = 32'hFFFF_FFFF; cin = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset operand", op, 32'd0);
        check("R9 reset carry/undef", {30'd0, cout, und}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 constant form
        drive(f_imm(32'hE000_0000, 4'd0, 8'hFF), 32'h1234_5678, 0, 1, 32'h0000_00FF, 1, 0, 1, "R1 rot0");
        drive(f_imm(32'hE000_0000, 4'd4, 8'hAB), 32'h0, 0, 0, 32'hAB00_0000, 1, 0, 1, "R1 rot8");
        drive(f_imm(32'h0000_0000, 4'd1, 8'h01), 32'h0, 0, 1, 32'h4000_0000, 0, 0, 1, "R1 rot2");
        // R2 constant amounts
        drive(f_rsi(5'd4, 2'b00), 32'h1000_000F, 0, 0, 32'h0000_00F0, 1, 0, 1, "R2 lsl4");
        drive(f_rsi(5'd8, 2'b01), 32'hF000_0080, 0, 0, 32'h00F0_0000, 1, 0, 1, "R2 lsr8");
        drive(f_rsi(5'd4, 2'b10), 32'h8000_0010, 0, 1, 32'hF800_0001, 0, 0, 1, "R2 asr4");
        drive(f_rsi(5'd8, 2'b11), 32'h1234_5678, 0, 1, 32'h7812_3456, 0, 0, 1, "R2 ror8");
        // R3 zero constant amounts
        drive(f_rsi(5'd0, 2'b00), 32'h1234_5678, 0, 1, 32'h1234_5678, 1, 0, 1, "R3 lsl0");
        drive(f_rsi(5'd0, 2'b01), 32'h8000_0001, 0, 0, 32'h0000_0000, 1, 0, 1, "R3 lsr0");
        drive(f_rsi(5'd0, 2'b10), 32'h8000_0000, 0, 0, 32'hFFFF_FFFF, 1, 0, 1, "R3 asr0");
        // R4 rotate through carry
        drive(f_rsi(5'd0, 2'b11), 32'h0000_0003, 0, 1, 32'h8000_0001, 1, 0, 1, "R4 rrx c1");
        drive(f_rsi(5'd0, 2'b11), 32'h0000_0002, 0, 0, 32'h0000_0001, 0, 0, 1, "R4 rrx c0");
        // R5 register amounts
        drive(f_rsr(2'b00, 0), 32'hDEAD_BEEF, 32'h0000_0100, 1, 32'hDEAD_BEEF, 1, 0, 1, "R5 zero low byte");
        drive(f_rsr(2'b01, 0), 32'h0000_0003, 32'hFFFF_FF01, 0, 32'h0000_0001, 1, 0, 1, "R5 lsr1 upper ignored");
        // R6 logical large amounts
        drive(f_rsr(2'b00, 0), 32'h0000_0001, 32'd32, 0, 32'h0, 1, 0, 1, "R6 lsl32");
        drive(f_rsr(2'b00, 0), 32'hFFFF_FFFF, 32'd33, 1, 32'h0, 0, 0, 1, "R6 lsl33");
        drive(f_rsr(2'b01, 0), 32'h8000_0000, 32'd32, 0, 32'h0, 1, 0, 1, "R6 lsr32");
        drive(f_rsr(2'b01, 0), 32'hFFFF_FFFF, 32'd40, 1, 32'h0, 0, 0, 1, "R6 lsr40");
        // R7 arithmetic and rotate large amounts
        drive(f_rsr(2'b10, 0), 32'h8000_0000, 32'd200, 0, 32'hFFFF_FFFF, 1, 0, 1, "R7 asr200");
        drive(f_rsr(2'b10, 0), 32'h7FFF_FFFF, 32'd100, 1, 32'h0, 0, 0, 1, "R7 asr100");
        drive(f_rsr(2'b11, 0), 32'h8000_0001, 32'd32, 0, 32'h8000_0001, 1, 0, 1, "R7 ror32");
        drive(f_rsr(2'b11, 0), 32'h0000_000F, 32'd36, 0, 32'hF000_0000, 1, 0, 1, "R7 ror36");
        // R8 undefined flag and ignored fields
        drive(f_rsr(2'b00, 1), 32'h1, 32'd1, 0, 32'h0, 0, 1, 0, "R8 bit7 set");
        drive(f_imm(32'h0000_0000, 4'd0, 8'h90), 32'h5, 32'h5, 0, 32'h0000_0090, 0, 0, 1, "R8 imm bit7/bit4");
        drive(f_rsi(5'd1, 2'b00) & 32'h0000_0FFF, 32'h0000_0001, 0, 0, 32'h0000_0002, 0, 0, 1, "R8 hi bits cleared");

        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R9 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule